// File: doc/BRIEF.md
# Parallel EEPROM Page Programmer with Completion Polling

This block sits on the host side of a byte-wide parallel EEPROM. On a start command it takes a page base address and a byte count of 1 to 128. It pulls that many bytes from a valid/ready byte source and strobes each byte into the device with a write-enable pulse. All bytes of one load stay inside the page selected by the upper address bits. The offset starts at the low bits of the base address and wraps inside the page.

After the last byte is loaded, the block does not wait a fixed worst-case programming time. It reads the device back until the device reports that programming has finished. In data mode it reads the last written address until bit 7 of the read value equals bit 7 of the last written byte. In toggle mode it compares bit 6 of consecutive reads until two of them agree. After completion it waits a settle interval, then pulses `done_o`. Two conditions end the operation with an `err_o` pulse instead: the poll runs past a timeout, or the source runs dry mid-page so that the byte-load window would close. All timings are parameters in clock cycles.

Top module: `ewr_page_writer`

## Requirements
- R1: During and right after reset, `ee_we_no`, `ee_oe_no` and `ee_ce_no` are high, `ee_doe_o`, `busy_o`, `src_ready_o`, `done_o` and `err_o` are low.
- R2: A start is taken only while idle and only with `count_i` in 1..128. Any other start, including one issued while busy, has no effect.
- R3: Each byte is written with `ee_we_no` low for exactly `WP_CYC` cycles, with `ee_ce_no` low and `ee_doe_o` high. Address and data are stable through the low pulse, and byte k carries the k-th byte taken from the source.
- R4: Byte k goes to address {base[14:7], (base[6:0]+k) mod 128}. Address bits 14:7 stay constant across the load.
- R5: Between bytes `ee_we_no` stays high for at least `WPH_CYC` cycles. Two consecutive falling edges of `ee_we_no` in one load are at most `BLC_MAX_CYC` cycles apart.
- R6: If the source offers no byte while the gap limit of R5 is about to be reached, the load ends early and the written bytes are polled to completion. The operation then ends with `err_o` instead of `done_o`.
- R7: With `mode_i`=0 (data mode), completion is the first read of the last written address whose bit 7 equals bit 7 of the last written byte.
- R8: With `mode_i`=1 (toggle mode), completion is a read whose bit 6 equals bit 6 of the preceding read in the same poll.
- R9: A poll read holds `ee_ce_no` and `ee_oe_no` low, `ee_we_no` high and `ee_doe_o` low for exactly `RD_CYC` cycles. `ee_oe_no` goes high between reads, and write enable and output enable are never low together.
- R10: After completion the bus stays idle for `DW_CYC` cycles before a one-cycle `done_o`. `busy_o` falls in the cycle `done_o` rises.
- R11: If completion is not seen within `TMO_CYC` cycles of the start of polling, `err_o` pulses for one cycle and the block returns to idle without `done_o`.
- R12: `done_o` and `err_o` are one-cycle pulses and never high together. `src_ready_o` is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a page load |
| base_addr_i | input | 15 | Page (bits 14:7) and first offset (bits 6:0) |
| count_i | input | 8 | Number of bytes, 1..128 |
| mode_i | input | 1 | 0 = data polling, 1 = toggle polling |
| src_valid_i | input | 1 | Source byte available |
| src_data_i | input | 8 | Source byte |
| src_ready_o | output | 1 | Writer takes the source byte |
| ee_addr_o | output | 15 | EEPROM address |
| ee_dout_o | output | 8 | EEPROM write data |
| ee_doe_o | output | 1 | Drive enable for write data |
| ee_din_i | input | 8 | EEPROM read data |
| ee_ce_no | output | 1 | Chip enable, active low |
| ee_oe_no | output | 1 | Output enable, active low |
| ee_we_no | output | 1 | Write enable, active low |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completed pulse |
| err_o | output | 1 | Timeout or short-load pulse |

## Verification
The assertions check on every cycle the bus-level properties of this block. Write and output enable are never low together. Write data and address hold still while write enable is low. Read cycles never drive the data bus. No falling write-enable edge in a load comes later than the byte-load limit or leaves the page. The end pulses are single and exclusive. Only the bench scenarios can show the properties that need an EEPROM on the other side: that each mode waits out a device that is still programming and is not fooled by the other mode's status bit, the settle delay after completion, the starved-source and timeout endings, and the wrap of the offset inside a page.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WE_LO, S_WE_HI, S_P_GAP, S_P_RD, S_HOLD
  } wr_state_e;

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } poll_mode_e;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ewr_tick.sv
module ewr_tick #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_o <= '0;
    else if (clr_i)          cnt_o <= '0;
    else if (cnt_o != '1)    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ewr_poll_eval.sv
module ewr_poll_eval
  import ewr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              sample_i,
  input  poll_mode_e        mode_i,
  input  logic              exp_bit_i,
  input  logic [DATA_W-1:0] rd_i,
  output logic              ok_o
);
  logic prev_q, have_q;
  logic unused_rd;

  assign unused_rd = ^rd_i[TOG_BIT-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else if (arm_i) begin
      have_q <= 1'b0;
    end else if (sample_i) begin
      have_q <= 1'b1;
      prev_q <= rd_i[TOG_BIT];
    end
  end

  always_comb begin
    if (mode_i == MODE_DATA) ok_o = sample_i && (rd_i[POLL_BIT] == exp_bit_i);
    else                     ok_o = sample_i && have_q && (rd_i[TOG_BIT] == prev_q);
  end
endmodule

// File: rtl/ewr_page_writer.sv
module ewr_page_writer
  import ewr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned PAGE_BYTES  = 128,
  parameter int unsigned WP_CYC      = 3,
  parameter int unsigned WPH_CYC     = 3,
  parameter int unsigned BLC_MAX_CYC = 4000,
  parameter int unsigned RD_CYC      = 4,
  parameter int unsigned DW_CYC      = 600,
  parameter int unsigned TMO_CYC     = 300000,
  localparam int unsigned OFF_W      = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W      = OFF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              mode_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic [ADDR_W-1:0] ee_addr_o,
  output logic [DATA_W-1:0] ee_dout_o,
  output logic              ee_doe_o,
  input  logic [DATA_W-1:0] ee_din_i,
  output logic              ee_ce_no,
  output logic              ee_oe_no,
  output logic              ee_we_no,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned PG_W  = ADDR_W - OFF_W;
  localparam int unsigned PH_W  = cnt_bits(max2(max2(WP_CYC, WPH_CYC), max2(RD_CYC, DW_CYC)));
  localparam int unsigned GAP_W = cnt_bits(BLC_MAX_CYC);
  localparam int unsigned TMO_W = cnt_bits(TMO_CYC);

  wr_state_e         state_q, state_d;
  logic [PG_W-1:0]   page_q;
  logic [OFF_W-1:0]  off_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dout_q;
  logic [CNT_W-1:0]  rem_q;
  poll_mode_e        mode_q;
  logic              short_q, loaded_q, done_q, err_q;

  logic [PH_W-1:0]   ph_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic [TMO_W-1:0]  tmo_cnt;
  logic              polling, start_ok, hs, starve, tmo_hit, sample, poll_ok;
  logic              we_lo_end, we_hi_end, rd_end, hold_end;

  assign polling   = (state_q == S_P_GAP) || (state_q == S_P_RD);
  assign start_ok  = (state_q == S_IDLE) && start_i && (count_i != '0) &&
                     (count_i <= CNT_W'(PAGE_BYTES));
  assign hs        = (state_q == S_FETCH) && src_valid_i;
  assign we_lo_end = ph_cnt == PH_W'(WP_CYC - 1);
  assign we_hi_end = ph_cnt == PH_W'(WPH_CYC - 1);
  assign rd_end    = ph_cnt == PH_W'(RD_CYC - 1);
  assign hold_end  = ph_cnt == PH_W'(DW_CYC - 1);
  // close the load one cycle early so the next falling edge cannot miss the window
  assign starve    = (state_q == S_FETCH) && !src_valid_i && loaded_q &&
                     (gap_cnt == GAP_W'(BLC_MAX_CYC - 1));
  assign tmo_hit   = polling && (tmo_cnt == TMO_W'(TMO_CYC - 1));
  assign sample    = (state_q == S_P_RD) && rd_end;

  ewr_tick #(.W(PH_W)) u_ph (
    .clk_i, .rst_ni, .clr_i(state_d != state_q), .cnt_o(ph_cnt)
  );
  ewr_tick #(.W(GAP_W)) u_gap (
    .clk_i, .rst_ni, .clr_i((state_d == S_WE_LO) && (state_q != S_WE_LO)), .cnt_o(gap_cnt)
  );
  ewr_tick #(.W(TMO_W)) u_tmo (
    .clk_i, .rst_ni, .clr_i(!polling), .cnt_o(tmo_cnt)
  );
  ewr_poll_eval u_eval (
    .clk_i, .rst_ni, .arm_i(!polling), .sample_i(sample), .mode_i(mode_q),
    .exp_bit_i(dout_q[POLL_BIT]), .rd_i(ee_din_i), .ok_o(poll_ok)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_ok) state_d = S_FETCH;
      S_FETCH: if (hs) state_d = S_WE_LO; else if (starve) state_d = S_P_GAP;
      S_WE_LO: if (we_lo_end) state_d = S_WE_HI;
      S_WE_HI: if (we_hi_end) state_d = (rem_q == '0) ? S_P_GAP : S_FETCH;
      S_P_GAP: state_d = tmo_hit ? S_IDLE : S_P_RD;
      S_P_RD: begin
        if (poll_ok)      state_d = S_HOLD;
        else if (tmo_hit) state_d = S_IDLE;
        else if (rd_end)  state_d = S_P_GAP;
      end
      S_HOLD:  if (hold_end) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      page_q   <= '0;
      off_q    <= '0;
      addr_q   <= '0;
      dout_q   <= '0;
      rem_q    <= '0;
      mode_q   <= MODE_DATA;
      short_q  <= 1'b0;
      loaded_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == S_HOLD) && hold_end && !short_q;
      err_q   <= ((state_q == S_HOLD) && hold_end && short_q) || (tmo_hit && !poll_ok);
      if (start_ok) begin
        page_q   <= base_addr_i[ADDR_W-1:OFF_W];
        off_q    <= base_addr_i[OFF_W-1:0];
        rem_q    <= count_i;
        mode_q   <= poll_mode_e'(mode_i);
        short_q  <= 1'b0;
        loaded_q <= 1'b0;
      end
      if (hs) begin
        addr_q   <= {page_q, off_q};
        off_q    <= off_q + 1'b1;
        dout_q   <= src_data_i;
        rem_q    <= rem_q - 1'b1;
        loaded_q <= 1'b1;
      end
      if (starve) short_q <= 1'b1;
    end
  end

  assign src_ready_o = (state_q == S_FETCH);
  assign ee_addr_o   = addr_q;
  assign ee_dout_o   = dout_q;
  assign ee_doe_o    = (state_q == S_WE_LO) || (state_q == S_WE_HI);
  assign ee_we_no    = (state_q != S_WE_LO);
  assign ee_oe_no    = (state_q != S_P_RD);
  assign ee_ce_no    = !((state_q == S_WE_LO) || (state_q == S_WE_HI) || (state_q == S_P_RD));
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/ewr_page_writer_chk.sv
module ewr_page_writer_chk #(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned OFF_W       = 7,
  parameter int unsigned BLC_MAX_CYC = 4000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ee_we_no,
  input logic              ee_oe_no,
  input logic              ee_ce_no,
  input logic              ee_doe_o,
  input logic [ADDR_W-1:0] ee_addr_o,
  input logic [7:0]        ee_dout_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              src_ready_o
);
  localparam int unsigned GC_W = $clog2(BLC_MAX_CYC + 2) + 1;

  logic                     we_q, in_load;
  logic                     fall;
  logic [GC_W-1:0]          gc;
  logic [ADDR_W-OFF_W-1:0]  page_r;

  assign fall = we_q && !ee_we_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b1;
      gc      <= '0;
      in_load <= 1'b0;
      page_r  <= '0;
    end else begin
      we_q <= ee_we_no;
      if (fall)            gc <= GC_W'(1);
      else if (gc != '1)   gc <= gc + 1'b1;
      if (!busy_o || !ee_oe_no) in_load <= 1'b0;
      else if (fall)            in_load <= 1'b1;
      if (fall && !in_load) page_r <= ee_addr_o[ADDR_W-1:OFF_W];
    end
  end

  a_r9_we_oe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ee_we_no && !ee_oe_no));
  a_r9_read_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_oe_no |-> (!ee_doe_o && !ee_ce_no));
  a_r3_we_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_we_no |-> (!ee_ce_no && ee_doe_o));
  a_r3_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ee_we_no && !$past(ee_we_no)) |-> ($stable(ee_dout_o) && $stable(ee_addr_o)));
  a_r5_blc_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && in_load) |-> (gc <= GC_W'(BLC_MAX_CYC)));
  a_r4_same_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && in_load) |-> (ee_addr_o[ADDR_W-1:OFF_W] == page_r));
  a_r12_done_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r12_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  a_r12_ready_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> busy_o);
endmodule

bind ewr_page_writer ewr_page_writer_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BLC_MAX_CYC(BLC_MAX_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ee_we_no(ee_we_no), .ee_oe_no(ee_oe_no),
  .ee_ce_no(ee_ce_no), .ee_doe_o(ee_doe_o), .ee_addr_o(ee_addr_o), .ee_dout_o(ee_dout_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .src_ready_o(src_ready_o)
);

// File: tb/tb_ewr_page_writer.sv
module tb_ewr_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int WP = 3, WPH = 2, BLC = 12, RD = 2, DW = 5, TMO = 300;

  typedef struct { logic [14:0] a; logic [7:0] d; } wr_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, src_valid = 1'b0;
  logic [14:0] base = '0;
  logic [7:0]  cnt = '0, src_data = '0, ee_din = '0;
  logic src_ready, doe, ce_n, oe_n, we_n, busy, done, err;
  logic [14:0] ee_addr;
  logic [7:0]  ee_dout;

  ewr_page_writer #(.WP_CYC(WP), .WPH_CYC(WPH), .BLC_MAX_CYC(BLC), .RD_CYC(RD),
                    .DW_CYC(DW), .TMO_CYC(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base), .count_i(cnt),
    .mode_i(mode), .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .ee_addr_o(ee_addr), .ee_dout_o(ee_dout), .ee_doe_o(doe), .ee_din_i(ee_din),
    .ee_ce_no(ce_n), .ee_oe_no(oe_n), .ee_we_no(we_n), .busy_o(busy), .done_o(done), .err_o(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  wr_t exp_wr[$];
  bit  exp_res[$];
  string cur_req = "R1";

  // EEPROM model state
  logic [7:0] mem [int];
  wr_t pend[$];
  bit m_load = 0, m_busy = 0, tog_en = 1, cpl_en = 1;
  logic m_tog = 0, we_p = 1, oe_p = 1;
  logic [7:0] m_last_d = '0, page_ref = '0;
  logic [14:0] lat_a = '0;
  int m_gap = 0, m_left = 0, prog_cyc = 10, prog_end = 0, we_lo_len = 0, we_hi_len = 0, rd_len = 0;

  // source state
  logic [7:0] src_buf[$];
  int s_idx = 0, stall = 0;
  bit hs_f = 0, stall_en = 0;

  function automatic logic [7:0] mem_rd(input logic [14:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      // source driver
      if (hs_f) begin
        s_idx++;
        if (stall_en && (s_idx % 7 == 0)) stall = 3;
      end else if (stall > 0) stall--;
      src_valid = (stall == 0) && (s_idx < src_buf.size());
      src_data  = src_valid ? src_buf[s_idx] : 8'h00;
      hs_f      = src_valid && src_ready;

      // programming progress
      if (m_busy) begin
        m_left--;
        if (m_left <= 0) begin
          foreach (pend[i]) mem[int'(pend[i].a)] = pend[i].d;
          pend.delete();
          m_busy = 0;
          prog_end = cyc;
        end
      end
      if (m_load) m_gap++;
      if (!we_n) we_lo_len++;
      else if (m_load) we_hi_len++;

      // write-enable falling edge
      if (we_p && !we_n) begin
        if (!m_load) begin
          m_load = 1;
          page_ref = ee_addr[14:7];
        end else begin
          chk(m_gap <= BLC, "R5", "WE falling-edge spacing", m_gap, BLC);
          chk(we_hi_len >= WPH, "R5", "WE high recovery", we_hi_len, WPH);
        end
        chk(ee_addr[14:7] == page_ref, "R4", "page bits", ee_addr[14:7], page_ref);
        chk(!ce_n && doe && oe_n, "R3", "CE/OE/drive during WE low", {ce_n, doe, oe_n}, 3'b011);
        lat_a = ee_addr;
        m_gap = 0;
        we_lo_len = 1;
      end
      // write-enable rising edge: scoreboard compare
      if (!we_p && we_n) begin
        chk(we_lo_len == WP, "R3", "WE low width", we_lo_len, WP);
        pend.push_back('{a: lat_a, d: ee_dout});
        m_last_d = ee_dout;
        if (exp_wr.size() == 0) chk(0, cur_req, "unexpected byte write", lat_a, 0);
        else begin
          wr_t e;
          e = exp_wr.pop_front();
          chk(lat_a == e.a, "R4", "write address", lat_a, e.a);
          chk(ee_dout == e.d, "R3", "write data", ee_dout, e.d);
        end
        we_hi_len = 0;
      end

      // output-enable falling edge: read
      if (oe_p && !oe_n) begin
        chk(we_n && !doe && !ce_n, "R9", "read strobes", {we_n, doe, ce_n}, 3'b100);
        if (m_load) begin
          m_load = 0;
          m_busy = 1;
          m_left = prog_cyc;
        end
        if (m_busy) begin
          logic [7:0] v;
          v = mem_rd(ee_addr);
          v[7] = cpl_en ? ~m_last_d[7] : m_last_d[7];
          if (tog_en) m_tog = ~m_tog;
          v[6] = m_tog;
          ee_din = v;
        end else ee_din = mem_rd(ee_addr);
        rd_len = 0;
      end
      if (!oe_n) rd_len++;
      if (!oe_p && oe_n) chk(rd_len == RD, "R9", "read length", rd_len, RD);
      if (m_load && m_gap > BLC + 4) begin
        m_load = 0;
        m_busy = 1;
        m_left = prog_cyc;
      end
      we_p = we_n;
      oe_p = oe_n;

      // result monitor
      if (done || err) begin
        chk(!(done && err), "R12", "done and err together", {done, err}, 2'b10);
        chk(!busy, "R10", "busy low with end pulse", busy, 0);
        if (exp_res.size() == 0) chk(0, "R12", "unexpected end pulse", {done, err}, 0);
        else begin
          bit e;
          e = exp_res.pop_front();
          chk(err == e, cur_req, "err flag at end", err, e);
          if (done && !e) begin
            chk(!m_busy, cur_req, "done while programming", m_busy, 0);
            chk(cyc - prog_end >= DW + RD, "R10", "settle after completion", cyc - prog_end, DW + RD);
            chk(cyc - prog_end <= DW + 4 * (RD + 1) + 2, cur_req, "completion latency",
                cyc - prog_end, DW + 4 * (RD + 1) + 2);
          end
        end
      end
    end
  end

  task automatic run_page(input logic [14:0] b, input int n, input bit md, input int plen,
                          input int nsrc, input bit tg, input bit cp, input bit stl,
                          input bit exp_err, input logic [7:0] seed, input string req);
    cur_req  = req;
    prog_cyc = plen;
    tog_en   = tg;
    cpl_en   = cp;
    stall_en = stl;
    src_buf.delete();
    for (int k = 0; k < nsrc; k++) src_buf.push_back(8'(k * 37) ^ seed);
    for (int k = 0; k < n && k < nsrc; k++)
      exp_wr.push_back('{a: {b[14:7], 7'(b[6:0] + 7'(k))}, d: 8'(k * 37) ^ seed});
    exp_res.push_back(exp_err);
    s_idx = 0;
    stall = 0;
    hs_f  = 0;
    @(negedge clk);
    start = 1'b1;
    base  = b;
    cnt   = 8'(n);
    mode  = md;
    @(negedge clk);
    start = 1'b0;
    while (exp_res.size() != 0) @(negedge clk);
    chk(exp_wr.size() == 0, req, "bytes left unwritten", exp_wr.size(), 0);
    exp_wr.delete();
    if (m_busy && plen > TMO) begin
      m_busy = 0;
      pend.delete();
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic bad_start(input logic [7:0] n, input string req);
    @(negedge clk);
    start = 1'b1;
    cnt   = n;
    base  = 15'h0100;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && we_n && !src_ready, req, "start ignored", {busy, we_n, src_ready}, 3'b010);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(we_n && oe_n && ce_n, "R1", "strobes in reset", {we_n, oe_n, ce_n}, 3'b111);
    chk(!doe && !busy && !src_ready, "R1", "drive/busy/ready in reset", {doe, busy, src_ready}, 0);
    chk(!done && !err, "R1", "end pulses in reset", {done, err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(we_n && oe_n && ce_n && !busy, "R1", "idle after reset", {we_n, oe_n, ce_n, busy}, 4'b1110);

    // R2 invalid counts ignored
    bad_start(8'd0, "R2");
    bad_start(8'd129, "R2");

    // R7 data polling, toggle bit frozen so only bit 7 can end the poll
    run_page(15'h1234, 8, 1'b0, 40, 8, 1'b0, 1'b1, 1'b0, 1'b0, 8'h85, "R7");
    // R4 offset wrap inside a page
    run_page(15'h2A7C, 10, 1'b0, 30, 10, 1'b1, 1'b1, 1'b0, 1'b0, 8'h11, "R4");
    // R8 toggle polling, bit 7 never complemented so only bit 6 can end the poll
    run_page(15'h0500, 5, 1'b1, 45, 5, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, "R8");
    // R8 single byte, toggle mode
    run_page(15'h7FFF, 1, 1'b1, 20, 1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hF0, "R8");
    // R5 full page with source stalls
    run_page(15'h4000, 128, 1'b0, 60, 128, 1'b1, 1'b1, 1'b1, 1'b0, 8'h5A, "R5");
    // R6 source runs dry after 4 of 10 bytes
    run_page(15'h3310, 10, 1'b0, 25, 4, 1'b1, 1'b1, 1'b0, 1'b1, 8'h77, "R6");
    // R11 device never finishes
    run_page(15'h6000, 3, 1'b0, 100000, 3, 1'b1, 1'b1, 1'b0, 1'b1, 8'h21, "R11");
    // R2 start while busy is ignored
    fork
      run_page(15'h0A00, 12, 1'b1, 30, 12, 1'b1, 1'b1, 1'b0, 1'b0, 8'h96, "R2");
      begin
        repeat (12) @(negedge clk);
        start = 1'b1;
        base  = 15'h7F00;
        cnt   = 8'd3;
        @(negedge clk);
        start = 1'b0;
      end
    join
    // R10 back-to-back page after completion
    run_page(15'h0A0C, 4, 1'b0, 15, 4, 1'b1, 1'b1, 1'b0, 1'b0, 8'h01, "R10");
    // R3 read back of programmed contents
    chk(mem_rd(15'h1234) == 8'h85, "R3", "stored byte 0", mem_rd(15'h1234), 8'h85);
    chk(mem_rd(15'h2A00) == (8'(4 * 37) ^ 8'h11), "R4", "wrapped byte", mem_rd(15'h2A00), 8'(4 * 37) ^ 8'h11);
    chk(mem_rd(15'h7F00) == 8'h00, "R2", "ignored start wrote nothing", mem_rd(15'h7F00), 0);
    chk(!mem.exists(int'(15'h3314)), "R6", "no byte past starvation", 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule